// File: doc/BRIEF.md
# Asynchronous Character Receiver with Parity-Tagged Entries

This block takes a serial asynchronous line that is sampled at sixteen times the bit rate and turns each character into one 16-bit entry ready to be written into a receive FIFO. A character has a start bit, then 5, 6, 7 or 8 data bits sent LSB first, an optional parity bit, and one or two stop bits. The receiver checks the parity bit in any of four modes and checks every stop bit. Unlike a plain receiver, it keeps the received parity bit with the character.

The parity bit is placed in one of two ways. It can sit directly above the data MSB inside the data byte, or it can go in the LSB of a status byte that travels with the character. The status byte also holds a parity error flag and a framing error flag. A one-cycle interrupt pulse marks each entry that carries a parity error.

The sample enable comes from an external baud generator. All configuration inputs are treated as static while a character is being received.

Top module: `async_char_rx`

## Requirements
- R1: A start is taken only from a high-to-low change of the synchronised line, and only if the line is still low at the start bit's middle sample (8 sample ticks later). A shorter low pulse produces no entry.
- R2: The data length is 5 + `cfgLen` bits (`cfgLen` 00=5 … 11=8). Data bits are taken LSB first, 16 ticks apart. The entry is data byte `outEntry[7:0]` plus status byte `outEntry[15:8]`. Data byte bits not used by the character or the parity are 0, and `outEntry[13:9]` is always 0.
- R3: With `cfgParEn`=1, `cfgParMode` picks the expected parity: 00 a constant 0, 01 odd (data plus parity has an odd count of ones), 10 even, 11 a constant 1. A mismatch sets `outEntry[15]`.
- R4: With `cfgParEn`=0, no parity bit is expected on the line. `outEntry[15]` and `outEntry[8]` are 0 and no interrupt is raised.
- R5: For 5 to 7 data bits with parity on and `cfgAdjSel`=0, the received parity bit is stored at `outEntry[5+cfgLen]`. With `cfgAdjSel`=1 it is not stored, and that bit is 0.
- R6: For 8 data bits with parity on and `cfgStatSel`=1, the received parity bit is stored at `outEntry[8]`. Otherwise `outEntry[8]` is 0.
- R7: With `cfgTwoStop`=0 one stop bit is checked, and with 1 two are checked. Any stop bit sampled low sets `outEntry[14]`. The entry is emitted after the middle sample of the last stop bit that is checked; a low first stop bit ends the character at once.
- R8: After a framing error the receiver goes idle and needs a new high-to-low change. A line held low produces exactly one entry.
- R9: `outValid` is high for one cycle per character. `parErrIrq` is high exactly in the cycle of an entry whose `outEntry[15]` is set.
- R10: Only cycles with `sampleTick` high move the receiver forward. With `sampleTick` held low, no entry appears, and a slower tick rate scales the bit timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleTick | input | 1 | Sample enable, 16 per bit time |
| rxLine | input | 1 | Serial receive line, idle high |
| cfgLen | input | 2 | Data length code, 5 + value bits |
| cfgParEn | input | 1 | Parity bit present and checked |
| cfgParMode | input | 2 | Parity mode: 00 zero, 01 odd, 10 even, 11 one |
| cfgTwoStop | input | 1 | Two stop bits when set |
| cfgAdjSel | input | 1 | Clear: parity stored above data MSB for 5–7 bit characters |
| cfgStatSel | input | 1 | Set: parity stored in status LSB for 8-bit characters |
| outEntry | output | 16 | Status byte [15:8] and data byte [7:0] |
| outValid | output | 1 | One-cycle entry strobe |
| parErrIrq | output | 1 | One-cycle parity error interrupt |

## Verification
A parity error and a framing error can both land in the same entry, together with the interrupt pulse in that entry's valid cycle. The bench provokes this with a character that has a wrong parity bit and a low stop bit. It then requires both status flags set, the exact data byte, and one interrupt pulse in the cycle where `outValid` is high. The vector table also covers a stop failure on the second stop bit alone, a line held low that ends in a framing error, and operation at half the tick rate.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2
  } rxState_t;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic clear;     // new character begins
    logic shiftBit;  // take a data bit
    logic takePar;   // take the parity bit
    logic stopFail;  // a stop bit was sampled low
    logic emit;      // character complete
  } rxStrobe_t;

  localparam int ENTRY_W  = 16;
  localparam int BYTE_W   = 8;
  localparam int MIN_BITS = 5;

endpackage

// File: rtl/async_rx_ctrl.sv
module async_rx_ctrl
  import async_rx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int MAX_BITS      = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleTick,
  input  logic      lineNow,
  input  logic      lineWas,
  input  logic [1:0] cfgLen,
  input  logic      cfgParEn,
  input  logic      cfgTwoStop,
  output rxStrobe_t stb
);

  localparam int CNT_W = $clog2(TICKS_PER_BIT);
  localparam int IDX_W = $clog2(MAX_BITS);
  localparam logic [CNT_W-1:0] MID_CNT = CNT_W'(TICKS_PER_BIT / 2 - 1);
  localparam logic [CNT_W-1:0] END_CNT = CNT_W'(TICKS_PER_BIT - 1);

  rxState_t         state, stateNxt;
  logic [CNT_W-1:0] tickCnt, tickCntNxt;
  logic [IDX_W-1:0] bitIdx, bitIdxNxt;
  logic [IDX_W-1:0] lastIdx;
  logic             atEnd;
  logic             fallSeen;

  assign lastIdx  = IDX_W'(cfgLen) + IDX_W'(MIN_BITS - 1);
  assign atEnd    = sampleTick && (tickCnt == END_CNT);
  assign fallSeen = sampleTick && lineWas && !lineNow;

  always_comb begin
    stateNxt   = state;
    tickCntNxt = tickCnt;
    bitIdxNxt  = bitIdx;
    stb        = '0;
    if (sampleTick && state != ST_IDLE) begin
      tickCntNxt = atEnd ? '0 : tickCnt + 1'b1;
    end
    unique case (state)
      ST_IDLE: begin
        if (fallSeen) begin
          stateNxt   = ST_START;
          tickCntNxt = '0;
          stb.clear  = 1'b1;
        end
      end
      ST_START: begin
        if (sampleTick && tickCnt == MID_CNT) begin
          tickCntNxt = '0;
          bitIdxNxt  = '0;
          stateNxt   = lineNow ? ST_IDLE : ST_DATA;
        end
      end
      ST_DATA: begin
        if (atEnd) begin
          stb.shiftBit = 1'b1;
          if (bitIdx == lastIdx) begin
            stateNxt = cfgParEn ? ST_PAR : ST_STOP1;
          end else begin
            bitIdxNxt = bitIdx + 1'b1;
          end
        end
      end
      ST_PAR: begin
        if (atEnd) begin
          stb.takePar = 1'b1;
          stateNxt    = ST_STOP1;
        end
      end
      ST_STOP1: begin
        if (atEnd) begin
          if (!lineNow) begin
            stb.stopFail = 1'b1;
            stb.emit     = 1'b1;
            stateNxt     = ST_IDLE;
          end else if (cfgTwoStop) begin
            stateNxt = ST_STOP2;
          end else begin
            stb.emit = 1'b1;
            stateNxt = ST_IDLE;
          end
        end
      end
      ST_STOP2: begin
        if (atEnd) begin
          stb.stopFail = !lineNow;
          stb.emit     = 1'b1;
          stateNxt     = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      state   <= stateNxt;
      tickCnt <= tickCntNxt;
      bitIdx  <= bitIdxNxt;
    end
  end

endmodule

// File: rtl/async_rx_dp.sv
module async_rx_dp
  import async_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleTick,
  input  logic               rxLine,
  input  logic [1:0]         cfgLen,
  input  logic               cfgParEn,
  input  logic [1:0]         cfgParMode,
  input  logic               cfgAdjSel,
  input  logic               cfgStatSel,
  input  rxStrobe_t          stb,
  output logic               lineNow,
  output logic               lineWas,
  output logic [ENTRY_W-1:0] outEntry,
  output logic               outValid,
  output logic               parErrIrq
);

  localparam int NB_W = $clog2(BYTE_W + 1);

  logic [SYNC_STAGES-1:0] syncSr;
  logic [BYTE_W-1:0]      dataSr;
  logic                   parBit;
  logic                   frameErr;

  logic [NB_W-1:0]        nBits;
  logic [BYTE_W-1:0]      charData;
  logic [BYTE_W-1:0]      dataByte;
  logic [BYTE_W-1:0]      statByte;
  logic                   expPar;
  logic                   parErr;
  logic                   frameNow;
  logic                   adjStore;
  logic                   statStore;

  // line synchroniser, idle level high
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncSr <= '1;
        else       syncSr <= rxLine;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncSr <= '1;
        else       syncSr <= {syncSr[SYNC_STAGES-2:0], rxLine};
      end
    end
  endgenerate

  assign lineNow = syncSr[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           lineWas <= 1'b1;
    else if (sampleTick) lineWas <= lineNow;
  end

  // character capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataSr   <= '0;
      parBit   <= 1'b0;
      frameErr <= 1'b0;
    end else if (stb.clear) begin
      dataSr   <= '0;
      parBit   <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      if (stb.shiftBit) dataSr   <= {lineNow, dataSr[BYTE_W-1:1]};
      if (stb.takePar)  parBit   <= lineNow;
      if (stb.stopFail) frameErr <= 1'b1;
    end
  end

  assign nBits    = NB_W'(MIN_BITS) + NB_W'(cfgLen);
  assign charData = dataSr >> (NB_W'(BYTE_W) - nBits);
  assign frameNow = frameErr | stb.stopFail;

  always_comb begin
    unique case (cfgParMode)
      2'b00:   expPar = 1'b0;
      2'b01:   expPar = ~(^charData);
      2'b10:   expPar = ^charData;
      default: expPar = 1'b1;
    endcase
  end

  assign parErr    = cfgParEn && (parBit != expPar);
  assign adjStore  = cfgParEn && !cfgAdjSel && (nBits < NB_W'(BYTE_W));
  assign statStore = cfgParEn && cfgStatSel && (nBits == NB_W'(BYTE_W));

  // data byte: character bits, then the optional adjacent parity bit
  generate
    for (genvar b = 0; b < BYTE_W; b++) begin : g_dbit
      always_comb begin
        if (NB_W'(b) < nBits)       dataByte[b] = charData[b];
        else if (NB_W'(b) == nBits) dataByte[b] = adjStore & parBit;
        else                        dataByte[b] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    statByte    = '0;
    statByte[7] = parErr;
    statByte[6] = frameNow;
    statByte[0] = statStore & parBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outEntry  <= '0;
      outValid  <= 1'b0;
      parErrIrq <= 1'b0;
    end else begin
      outValid  <= stb.emit;
      parErrIrq <= stb.emit & parErr;
      if (stb.emit) outEntry <= {statByte, dataByte};
    end
  end

endmodule

// File: rtl/async_char_rx.sv
module async_char_rx
  import async_rx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleTick,
  input  logic        rxLine,
  input  logic [1:0]  cfgLen,
  input  logic        cfgParEn,
  input  logic [1:0]  cfgParMode,
  input  logic        cfgTwoStop,
  input  logic        cfgAdjSel,
  input  logic        cfgStatSel,
  output logic [15:0] outEntry,
  output logic        outValid,
  output logic        parErrIrq
);

  rxStrobe_t stb;
  logic      lineNow;
  logic      lineWas;

  async_rx_ctrl #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .MAX_BITS     (BYTE_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sampleTick(sampleTick),
    .lineNow   (lineNow),
    .lineWas   (lineWas),
    .cfgLen    (cfgLen),
    .cfgParEn  (cfgParEn),
    .cfgTwoStop(cfgTwoStop),
    .stb       (stb)
  );

  async_rx_dp #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sampleTick(sampleTick),
    .rxLine    (rxLine),
    .cfgLen    (cfgLen),
    .cfgParEn  (cfgParEn),
    .cfgParMode(cfgParMode),
    .cfgAdjSel (cfgAdjSel),
    .cfgStatSel(cfgStatSel),
    .stb       (stb),
    .lineNow   (lineNow),
    .lineWas   (lineWas),
    .outEntry  (outEntry),
    .outValid  (outValid),
    .parErrIrq (parErrIrq)
  );

endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk (
  input logic        clk,
  input logic        rstN,
  input logic        sampleTick,
  input logic [1:0]  cfgLen,
  input logic        cfgParEn,
  input logic [15:0] outEntry,
  input logic        outValid,
  input logic        parErrIrq
);

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R9
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    parErrIrq |-> (outValid && outEntry[15]));

  // R9
  flag_gives_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outEntry[15]) |-> parErrIrq);

  // R4
  no_parity_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !cfgParEn) |-> (!outEntry[15] && !outEntry[8] && !parErrIrq));

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outEntry[13:9] == 5'd0));

  // R2
  short_char_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && cfgLen == 2'b00) |-> (outEntry[7:6] == 2'b00));

  // R10
  tick_gates_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleTick |=> !outValid);

endmodule

bind async_char_rx async_rx_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .sampleTick(sampleTick),
  .cfgLen    (cfgLen),
  .cfgParEn  (cfgParEn),
  .outEntry  (outEntry),
  .outValid  (outValid),
  .parErrIrq (parErrIrq)
);

// File: tb/sim_async_char_rx.sv
`timescale 1ns/1ps
module sim_async_char_rx;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleTick = 1'b1;
  logic        rxLine = 1'b1;
  logic [1:0]  cfgLen = 2'd3;
  logic        cfgParEn = 1'b0;
  logic [1:0]  cfgParMode = 2'd0;
  logic        cfgTwoStop = 1'b0;
  logic        cfgAdjSel = 1'b0;
  logic        cfgStatSel = 1'b0;
  logic [15:0] outEntry;
  logic        outValid;
  logic        parErrIrq;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit halfTick = 0;
  bit tickOff = 0;

  int          gotCnt = 0;
  int          irqCnt = 0;
  logic [15:0] gotEntry = '0;
  logic        gotIrq = 1'b0;

  always #10 clk = ~clk;

  async_char_rx u0 (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .cfgLen(cfgLen), .cfgParEn(cfgParEn), .cfgParMode(cfgParMode),
    .cfgTwoStop(cfgTwoStop), .cfgAdjSel(cfgAdjSel), .cfgStatSel(cfgStatSel),
    .outEntry(outEntry), .outValid(outValid), .parErrIrq(parErrIrq)
  );

  // tick generation, changed away from the active edge
  always @(negedge clk) begin
    if (tickOff)       sampleTick <= 1'b0;
    else if (halfTick) sampleTick <= ~sampleTick;
    else               sampleTick <= 1'b1;
  end

  // output monitor
  always @(negedge clk) begin
    if (outValid) begin
      gotCnt   = gotCnt + 1;
      gotEntry = outEntry;
      gotIrq   = parErrIrq;
    end
    if (parErrIrq) irqCnt = irqCnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic holdLine(input logic v, input int clocks);
    for (int i = 0; i < clocks; i++) begin
      @(negedge clk);
      rxLine = v;
    end
  endtask

  function automatic logic goodPar(input logic [1:0] mode, input logic [7:0] d);
    case (mode)
      2'b00:   return 1'b0;
      2'b01:   return ~(^d);
      2'b10:   return ^d;
      default: return 1'b1;
    endcase
  endfunction

  // expected entry from the requirements
  function automatic logic [15:0] expEntry(input logic [1:0] len, input logic pe,
      input logic [1:0] mode, input logic two, input logic adj, input logic st,
      input logic [7:0] data, input logic pb, input logic [1:0] sb);
    int n = 5 + int'(len);
    logic [7:0] d = data & 8'((1 << n) - 1);
    logic p = goodPar(mode, d) ^ pb;
    logic [7:0] db = d;
    logic [7:0] sbyte = 8'h00;
    if (pe && n < 8 && !adj) db[n] = p;               // R5
    if (pe && n == 8 && st) sbyte[0] = p;             // R6
    if (pe && pb) sbyte[7] = 1'b1;                    // R3
    if (sb == 2'd1 || (sb == 2'd2 && two)) sbyte[6] = 1'b1; // R7
    return {sbyte, db};
  endfunction

  task automatic sendChar(input logic [1:0] len, input logic pe, input logic [1:0] mode,
      input logic two, input logic [7:0] data, input logic pb, input logic [1:0] sb,
      input int cpb);
    int n = 5 + int'(len);
    logic [7:0] d = data & 8'((1 << n) - 1);
    holdLine(1'b0, cpb);
    for (int i = 0; i < n; i++) holdLine(d[i], cpb);
    if (pe) holdLine(goodPar(mode, d) ^ pb, cpb);
    holdLine(sb == 2'd1 ? 1'b0 : 1'b1, cpb);
    if (two) holdLine(sb == 2'd2 ? 1'b0 : 1'b1, cpb);
    holdLine(1'b1, 2 * cpb);
  endtask

  // {len, parEn, mode, twoStop, adjSel, statSel, data, parBad, stopBad}
  localparam int NV = 12;
  localparam logic [18:0] VEC [NV] = '{
    {2'd3, 1'b1, 2'b01, 1'b0, 1'b0, 1'b1, 8'hA5, 1'b0, 2'd0},
    {2'd3, 1'b1, 2'b10, 1'b1, 1'b0, 1'b1, 8'h3C, 1'b1, 2'd0},
    {2'd0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 8'h1F, 1'b0, 2'd0},
    {2'd1, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 8'h2A, 1'b1, 2'd0},
    {2'd2, 1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 8'h55, 1'b0, 2'd2},
    {2'd2, 1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 8'h7F, 1'b0, 2'd0},
    {2'd3, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 8'h81, 1'b0, 2'd0},
    {2'd3, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 8'hC3, 1'b0, 2'd0},
    {2'd0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b0, 2'd1},
    {2'd3, 1'b1, 2'b10, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 2'd1},
    {2'd1, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 8'h3F, 1'b1, 2'd0},
    {2'd2, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1, 8'h5A, 1'b0, 2'd2}
  };

  initial begin
    int c0;
    int i0;
    logic [15:0] e;
    // reset state
    repeat (3) @(negedge clk);
    chk("R9 reset valid", outValid, 0);
    chk("R9 reset irq", parErrIrq, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 idle valid", outValid, 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      cfgLen     = VEC[v][18:17];
      cfgParEn   = VEC[v][16];
      cfgParMode = VEC[v][15:14];
      cfgTwoStop = VEC[v][13];
      cfgAdjSel  = VEC[v][12];
      cfgStatSel = VEC[v][11];
      c0 = gotCnt;
      i0 = irqCnt;
      e = expEntry(VEC[v][18:17], VEC[v][16], VEC[v][15:14], VEC[v][13], VEC[v][12],
                   VEC[v][11], VEC[v][10:3], VEC[v][2], VEC[v][1:0]);
      sendChar(VEC[v][18:17], VEC[v][16], VEC[v][15:14], VEC[v][13], VEC[v][10:3],
               VEC[v][2], VEC[v][1:0], 16);
      chk($sformatf("R7 one entry v%0d", v), gotCnt - c0, 1);
      chk($sformatf("R2 R3 R5 R6 R7 entry v%0d", v), gotEntry, e);
      chk($sformatf("R9 irq level v%0d", v), gotIrq, e[15]);
      chk($sformatf("R9 irq count v%0d", v), irqCnt - i0, e[15] ? 1 : 0);
    end

    // R1: short low pulse is no start
    cfgLen = 2'd3; cfgParEn = 1'b0; cfgTwoStop = 1'b0;
    c0 = gotCnt;
    holdLine(1'b0, 3);
    holdLine(1'b1, 60);
    chk("R1 glitch ignored", gotCnt - c0, 0);

    // R8: line held low gives one framing entry
    c0 = gotCnt;
    holdLine(1'b0, 30 * 16);
    chk("R8 single break entry", gotCnt - c0, 1);
    chk("R8 break entry value", gotEntry, 16'h4000);
    holdLine(1'b1, 32);
    c0 = gotCnt;
    sendChar(2'd3, 1'b0, 2'b00, 1'b0, 8'h96, 1'b0, 2'd0, 16);
    chk("R8 recovery count", gotCnt - c0, 1);
    chk("R8 recovery entry", gotEntry, 16'h0096);

    // R10: no ticks, no progress
    tickOff = 1'b1;
    c0 = gotCnt;
    sendChar(2'd3, 1'b0, 2'b00, 1'b0, 8'h3C, 1'b0, 2'd0, 16);
    chk("R10 stalled no entry", gotCnt - c0, 0);
    tickOff = 1'b0;
    holdLine(1'b1, 16);

    // R10: half tick rate, 32 clocks per bit
    halfTick = 1'b1;
    cfgParEn = 1'b1; cfgParMode = 2'b01; cfgStatSel = 1'b1;
    c0 = gotCnt;
    e = expEntry(2'd3, 1'b1, 2'b01, 1'b0, 1'b0, 1'b1, 8'h6B, 1'b0, 2'd0);
    sendChar(2'd3, 1'b1, 2'b01, 1'b0, 8'h6B, 1'b0, 2'd0, 32);
    chk("R10 half rate count", gotCnt - c0, 1);
    chk("R10 half rate entry", gotEntry, e);
    halfTick = 1'b0;

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule